// File: doc/BRIEF.md
# UART Register File Emulation

This block presents the eight-register programming model of a classic 8250-style UART to an 8-bit CPU I/O bus. It has no serializer and no baud generator. A byte written to the transmit holding register goes straight to a device sink through a one-cycle strobe. Received bytes, modem-signal changes and line breaks arrive from device logic on a separate injection interface. The register behaviour seen by software is kept intact: the divisor latch switching, the sticky status flags cleared on read, and a prioritized interrupt identification driving a single request line.

Bus reads are combinational. `bus_rdata` shows the addressed register in the same cycle as `bus_rd`, and the side effects of the read (flags cleared) take hold at the next clock edge. Bus writes and injections take effect at the clock edge. The line status seen on a read is the internal status ORed with an external status vector, so device logic can contribute bits of its own. The transmitter-empty interrupt is detected only when software polls the line status register. It fires when that poll sees the holding register empty again after a data write.

Top module: `uart_rf_top`

## Requirements
- R1: After reset, IIR (offset 2) reads 0x01, LSR (offset 5) reads 0x60 with `ext_lsr` zero, MSR (offset 6), IER (offset 1) and data (offset 0) read 0x00, and `irq` and `tx_strobe` are low.
- R2: When LCR bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. Such a write produces no `tx_strobe` and leaves the IER unchanged.
- R3: A write to offset 0 with LCR bit 7 clear raises `tx_strobe` for exactly the following cycle, with `tx_byte` equal to the written byte. LSR bits 5 and 6 read 0 during that cycle and 1 again from the cycle after.
- R4: An LSR read returns {0, THRE, THRE, BI, FE, 0, OE, DR} (bit 7 down to bit 0) ORed with `ext_lsr`, and then clears OE, FE and BI. An error that is injected in the same cycle wins over the clear.
- R5: A read of offset 0 with LCR bit 7 clear returns the last received byte and clears DR. When MCR bit 4 (loopback) is set, the read also clears THRE for one cycle.
- R6: Each `rx_push` loads `rx_byte` into the receive register and sets DR. If DR was already set, it also sets OE.
- R7: `line_break` sets BI, FE and DR and loads 0x00 into the receive register.
- R8: MSR reads {CD, 0, DSR, CTS, dCD, 0, dDSR, dCTS}. `sig_raise` sets CTS, DSR and CD. `sig_lower` clears them. Either one sets all three delta bits. An MSR read clears the delta bits.
- R9: With IER bit 1 set, a transmitter-empty interrupt becomes pending only when an LSR read sees THRE at 1 after a data write that has not yet been followed by such a read. An IIR read that returns 0x02 clears it, and so does a data write. It does not return until another data write.
- R10: IIR reports the highest-priority enabled condition: line error (OE, FE or BI) 0x06, then DR 0x04, then pending transmitter-empty 0x02, then any modem delta 0x00, and otherwise 0x01. `irq` is high exactly when IIR is not 0x01.
- R11: IER bits 0, 1, 2 and 3 enable the receive, transmitter-empty, line-status and modem-status conditions. IER reads back its low four bits with the upper four bits at zero. A condition whose enable is clear never raises `irq`.
- R12: LCR (offset 3), MCR (offset 4) and the scratch register (offset 7) read back the full byte last written. Writes to offsets 2, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| rx_push | input | 1 | Inject a received byte |
| rx_byte | input | 8 | Byte to inject |
| sig_raise | input | 1 | Assert CTS, DSR and CD |
| sig_lower | input | 1 | Deassert CTS, DSR and CD |
| line_break | input | 1 | Signal a line break |
| ext_lsr | input | 8 | Status bits ORed into every LSR read |
| tx_strobe | output | 1 | One-cycle pulse per transmitted byte |
| tx_byte | output | 8 | Transmitted byte, valid with `tx_strobe` |
| irq | output | 1 | Interrupt request |

## Verification
The transmitter-empty interrupt is the hardest condition to reach from the ports. It needs a data write with IER bit 1 set, a cycle for THRE to come back, and then an LSR poll. The interrupt must then appear after that poll and after no other access. The stimulus covers three orders: polling once THRE has returned, polling in the very cycle after the write (THRE still 0, so nothing may fire until a second poll), and a repeat poll with no new write (which must not fire). It then clears the pending interrupt with both an IIR read and a data write. The loopback read is covered in the same way, because it drops THRE as a side effect of reading the receive register.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int IER_W  = 4;
    localparam int MS_N   = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IIR  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LCR  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_FE   = 3;
    localparam int LSR_BI   = 4;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;

    localparam int IEN_RX = 0;
    localparam int IEN_TX = 1;
    localparam int IEN_LS = 2;
    localparam int IEN_MS = 3;

    localparam int MCR_LOOP = 4;
    localparam int LCR_DLAB = 7;

    localparam logic [DATA_W-1:0] IIR_NONE = 8'h01;
    localparam logic [DATA_W-1:0] IIR_LS   = 8'h06;
    localparam logic [DATA_W-1:0] IIR_RX   = 8'h04;
    localparam logic [DATA_W-1:0] IIR_TX   = 8'h02;
    localparam logic [DATA_W-1:0] IIR_MS   = 8'h00;

    // decoded bus accesses with side effects
    typedef struct packed {
        logic rd_rbr;
        logic wr_thr;
        logic wr_dll;
        logic wr_dlm;
        logic wr_ier;
        logic rd_iir;
        logic wr_lcr;
        logic wr_mcr;
        logic rd_lsr;
        logic rd_msr;
        logic wr_scr;
    } acc_t;

    typedef struct packed {
        logic [DATA_W-1:0] rbr;
        logic [DATA_W-1:0] thr;
        logic [DATA_W-1:0] dll;
        logic [DATA_W-1:0] dlm;
        logic [DATA_W-1:0] lcr;
        logic [DATA_W-1:0] mcr;
        logic [DATA_W-1:0] scr;
        logic [IER_W-1:0]  ier;
        logic              dr;
        logic              oe;
        logic              fe;
        logic              bi;
        logic              thre;
        logic              armed;  // data written, no LSR poll yet has seen THRE return
        logic              thri;   // transmitter-empty interrupt pending
        logic              txs;
    } core_t;

    typedef struct packed {
        logic [MS_N-1:0] sig;   // 0 CTS, 1 DSR, 2 CD
        logic [MS_N-1:0] dlt;
    } msr_t;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              dlab,
    output acc_t              acc
);

    always_comb begin
        acc = '0;
        case (addr)
            OFS_DATA: begin
                acc.rd_rbr = rd && !dlab;
                acc.wr_thr = wr && !dlab;
                acc.wr_dll = wr && dlab;
            end
            OFS_IER: begin
                acc.wr_ier = wr && !dlab;
                acc.wr_dlm = wr && dlab;
            end
            OFS_IIR: acc.rd_iir = rd;
            OFS_LCR: acc.wr_lcr = wr;
            OFS_MCR: acc.wr_mcr = wr;
            OFS_LSR: acc.rd_lsr = rd;
            OFS_MSR: acc.rd_msr = rd;
            OFS_SCR: acc.wr_scr = wr;
            default: acc = '0;
        endcase
    end

endmodule

// File: rtl/uart_rf_msr.sv
module uart_rf_msr
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise,
    input  logic              lower,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] msr_byte,
    output logic              delta_any
);

    msr_t ms_d, ms_q;

    always_comb begin
        ms_d = ms_q;
        for (int i = 0; i < MS_N; i++) begin
            if (raise) begin
                ms_d.sig[i] = 1'b1;
                ms_d.dlt[i] = 1'b1;
            end else if (lower) begin
                ms_d.sig[i] = 1'b0;
                ms_d.dlt[i] = 1'b1;
            end else if (rd_clr) begin
                ms_d.dlt[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ms_q <= '0;
        else        ms_q <= ms_d;
    end

    assign msr_byte  = {ms_q.sig[2], 1'b0, ms_q.sig[1], ms_q.sig[0],
                        ms_q.dlt[2], 1'b0, ms_q.dlt[1], ms_q.dlt[0]};
    assign delta_any = |ms_q.dlt;

    // R8: a read with no concurrent signal event leaves no delta behind
    assert_msr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !raise && !lower) |=> (msr_byte[3:0] == 4'h0));

    // R8: raise drives all three signals high
    assert_msr_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> (msr_byte[7:4] == 4'hB));

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
    import uart_rf_pkg::*;
(
    input  logic [IER_W-1:0]  ier,
    input  logic              ls_pend,
    input  logic              rx_pend,
    input  logic              tx_pend,
    input  logic              ms_pend,
    output logic [DATA_W-1:0] iir,
    output logic              irq
);

    logic [3:0] hit;

    always_comb begin
        hit[3] = ls_pend && ier[IEN_LS];
        hit[2] = rx_pend && ier[IEN_RX];
        hit[1] = tx_pend && ier[IEN_TX];
        hit[0] = ms_pend && ier[IEN_MS];
        if (hit[3])      iir = IIR_LS;
        else if (hit[2]) iir = IIR_RX;
        else if (hit[1]) iir = IIR_TX;
        else if (hit[0]) iir = IIR_MS;
        else             iir = IIR_NONE;
        irq = |hit;
    end

endmodule

// File: rtl/uart_rf_top.sv
module uart_rf_top
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              sig_raise,
    input  logic              sig_lower,
    input  logic              line_break,
    input  logic [DATA_W-1:0] ext_lsr,
    output logic              tx_strobe,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq
);

    core_t             st_d, st_q;
    acc_t              acc;
    logic [DATA_W-1:0] msr_byte;
    logic              delta_any;
    logic [DATA_W-1:0] iir;
    logic [DATA_W-1:0] lsr_loc;
    logic              thre_clr;
    logic              err_any;

    uart_rf_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .dlab (st_q.lcr[LCR_DLAB]),
        .acc  (acc)
    );

    uart_rf_msr u_msr (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise     (sig_raise),
        .lower     (sig_lower),
        .rd_clr    (acc.rd_msr),
        .msr_byte  (msr_byte),
        .delta_any (delta_any)
    );

    assign err_any = st_q.oe || st_q.fe || st_q.bi;

    uart_rf_irq u_irq (
        .ier     (st_q.ier),
        .ls_pend (err_any),
        .rx_pend (st_q.dr),
        .tx_pend (st_q.thri),
        .ms_pend (delta_any),
        .iir     (iir),
        .irq     (irq)
    );

    always_comb begin
        lsr_loc           = '0;
        lsr_loc[LSR_DR]   = st_q.dr;
        lsr_loc[LSR_OE]   = st_q.oe;
        lsr_loc[LSR_FE]   = st_q.fe;
        lsr_loc[LSR_BI]   = st_q.bi;
        lsr_loc[LSR_THRE] = st_q.thre;
        lsr_loc[LSR_TEMT] = st_q.thre;
    end

    // read data, combinational on the current state
    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = st_q.lcr[LCR_DLAB] ? st_q.dll : st_q.rbr;
            OFS_IER:  bus_rdata = st_q.lcr[LCR_DLAB] ? st_q.dlm
                                : {{(DATA_W-IER_W){1'b0}}, st_q.ier};
            OFS_IIR:  bus_rdata = iir;
            OFS_LCR:  bus_rdata = st_q.lcr;
            OFS_MCR:  bus_rdata = st_q.mcr;
            OFS_LSR:  bus_rdata = lsr_loc | ext_lsr;
            OFS_MSR:  bus_rdata = msr_byte;
            default:  bus_rdata = st_q.scr;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        thre_clr = acc.wr_thr || (acc.rd_rbr && st_q.mcr[MCR_LOOP]);

        // transmit hand-off
        st_d.txs  = acc.wr_thr;
        if (acc.wr_thr) st_d.thr = bus_wdata;
        st_d.thre = !thre_clr;

        // transmitter-empty edge seen by an LSR poll
        if (thre_clr)                       st_d.armed = 1'b1;
        else if (acc.rd_lsr && st_q.thre)   st_d.armed = 1'b0;

        if (acc.wr_thr)
            st_d.thri = 1'b0;
        else if (acc.rd_lsr && st_q.thre && st_q.armed && st_q.ier[IEN_TX])
            st_d.thri = 1'b1;
        else if (acc.rd_iir && (iir == IIR_TX))
            st_d.thri = 1'b0;

        // receive side
        if (line_break)   st_d.rbr = '0;
        else if (rx_push) st_d.rbr = rx_byte;

        if (rx_push || line_break) st_d.dr = 1'b1;
        else if (acc.rd_rbr)       st_d.dr = 1'b0;

        st_d.oe = (rx_push && st_q.dr) || (st_q.oe && !acc.rd_lsr);
        st_d.fe = line_break || (st_q.fe && !acc.rd_lsr);
        st_d.bi = line_break || (st_q.bi && !acc.rd_lsr);

        // plain registers
        if (acc.wr_dll) st_d.dll = bus_wdata;
        if (acc.wr_dlm) st_d.dlm = bus_wdata;
        if (acc.wr_ier) st_d.ier = bus_wdata[IER_W-1:0];
        if (acc.wr_lcr) st_d.lcr = bus_wdata;
        if (acc.wr_mcr) st_d.mcr = bus_wdata;
        if (acc.wr_scr) st_d.scr = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.thre <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_strobe = st_q.txs;
    assign tx_byte   = st_q.thr;

    // R3: a data write hands the byte to the sink on the next cycle
    assert_tx_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr_thr |=> (tx_strobe && (tx_byte == $past(bus_wdata))));

    // R3: holding register reads busy during the hand-off cycle
    assert_thre_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr_thr |=> (bus_addr != OFS_LSR || !bus_rdata[LSR_THRE] || ext_lsr[LSR_THRE]));

    // R2: divisor writes never reach the sink
    assert_dlab_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && st_q.lcr[LCR_DLAB] && bus_addr == OFS_DATA) |=> !tx_strobe);

    // R5: reading the receive register clears data ready
    assert_dr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd_rbr && !rx_push && !line_break) |=> !st_q.dr);

    // R6: a second byte before a read is an overrun
    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && st_q.dr) |=> st_q.oe);

    // R7: break loads a null with its flags
    assert_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |=> (st_q.bi && st_q.fe && st_q.dr && st_q.rbr == '0));

    // R4: an LSR read with no new error clears all error flags
    assert_err_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd_lsr && !rx_push && !line_break) |=> !err_any);

    // R9: a transmitter-empty interrupt only ever appears after an LSR poll
    assert_thri_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.thri) |-> $past(acc.rd_lsr));

    // R10: an enabled line error wins the IIR
    assert_iir_ls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && st_q.ier[IEN_LS]) |-> (iir == IIR_LS));

    // R10: no request means the idle code
    assert_irq_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iir == IIR_NONE));

endmodule

// File: tb/tb_uart_rf_top.sv
module tb_uart_rf_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       sig_raise = 1'b0, sig_lower = 1'b0, line_break = 1'b0;
    logic [7:0] ext_lsr = '0;
    logic       tx_strobe;
    logic [7:0] tx_byte;
    logic       irq;

    always #10 clk = ~clk;

    uart_rf_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .sig_raise(sig_raise),
        .sig_lower(sig_lower), .line_break(line_break), .ext_lsr(ext_lsr),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_rbr = 0, m_dll = 0, m_dlm = 0, m_lcr = 0, m_mcr = 0, m_scr = 0, m_txb = 0;
    logic [3:0] m_ier = 0;
    logic m_dr = 0, m_oe = 0, m_fe = 0, m_bi = 0, m_thre = 1, m_armed = 0, m_thri = 0, m_txs = 0;
    logic m_sig = 0, m_dlt = 0;

    function automatic logic [7:0] m_iir();
        if ((m_oe || m_fe || m_bi) && m_ier[2]) return 8'h06;
        if (m_dr && m_ier[0])                   return 8'h04;
        if (m_thri && m_ier[1])                 return 8'h02;
        if (m_dlt && m_ier[3])                  return 8'h00;
        return 8'h01;
    endfunction

    function automatic logic [7:0] m_rd(input logic [2:0] a, input logic [7:0] ex);
        case (a)
            3'd0: return m_lcr[7] ? m_dll : m_rbr;
            3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
            3'd2: return m_iir();
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            3'd5: return {1'b0, m_thre, m_thre, m_bi, m_fe, 1'b0, m_oe, m_dr} | ex;
            3'd6: return {m_sig, 1'b0, m_sig, m_sig, m_dlt, 1'b0, m_dlt, m_dlt};
            default: return m_scr;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? "R2" : "R5";
            3'd1: return m_lcr[7] ? "R2" : "R11";
            3'd2: return "R10";
            3'd5: return "R4";
            3'd6: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // one bus/backside cycle, starting after a falling edge
    task automatic op(input logic [2:0] a, input logic r, input logic w, input logic [7:0] d,
                      input logic p, input logic [7:0] pb, input logic ra, input logic lo,
                      input logic br, input logic [7:0] ex, output logic [7:0] got);
        logic dl, thrw, lbrd, rbrrd, lsrrd, iirrd, msrrd, o_thre, o_armed, o_dr;
        logic [7:0] o_iir;
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d; rx_push = p; rx_byte = pb;
        sig_raise = ra; sig_lower = lo; line_break = br; ext_lsr = ex;
        #2;
        chk("R10", {7'h0, irq}, {7'h0, (m_iir() != 8'h01)});
        chk("R3", {7'h0, tx_strobe}, {7'h0, m_txs});
        if (m_txs) chk("R3", tx_byte, m_txb);
        if (r) chk(tag_of(a), bus_rdata, m_rd(a, ex));
        got = bus_rdata;
        @(posedge clk);
        dl = m_lcr[7];
        thrw = w && a == 3'd0 && !dl;
        rbrrd = r && a == 3'd0 && !dl;
        lbrd = rbrrd && m_mcr[4];
        lsrrd = r && a == 3'd5;
        iirrd = r && a == 3'd2;
        msrrd = r && a == 3'd6;
        o_iir = m_iir(); o_thre = m_thre; o_armed = m_armed; o_dr = m_dr;
        m_txs = thrw;
        if (thrw) m_txb = d;
        m_thre = !(thrw || lbrd);
        if (thrw || lbrd) m_armed = 1;
        else if (lsrrd && o_thre) m_armed = 0;
        if (thrw) m_thri = 0;
        else if (lsrrd && o_thre && o_armed && m_ier[1]) m_thri = 1;
        else if (iirrd && o_iir == 8'h02) m_thri = 0;
        if (br) m_rbr = 0; else if (p) m_rbr = pb;
        if (p || br) m_dr = 1; else if (rbrrd) m_dr = 0;
        m_oe = (p && o_dr) || (m_oe && !lsrrd);
        m_fe = br || (m_fe && !lsrrd);
        m_bi = br || (m_bi && !lsrrd);
        if (ra) begin m_sig = 1; m_dlt = 1; end
        else if (lo) begin m_sig = 0; m_dlt = 1; end
        else if (msrrd) m_dlt = 0;
        if (w && a == 3'd0 && dl) m_dll = d;
        if (w && a == 3'd1 && dl) m_dlm = d;
        if (w && a == 3'd1 && !dl) m_ier = d[3:0];
        if (w && a == 3'd3) m_lcr = d;
        if (w && a == 3'd4) m_mcr = d;
        if (w && a == 3'd7) m_scr = d;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; rx_push = 0; sig_raise = 0; sig_lower = 0; line_break = 0;
    endtask

    logic [7:0] g;

    task automatic idle();   op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, g); endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d); op(a, 0, 1, d, 0, 0, 0, 0, 0, 0, g); endtask
    task automatic push(input logic [7:0] b); op(0, 0, 0, 0, 1, b, 0, 0, 0, 0, g); endtask
    task automatic brk();    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, g); endtask
    task automatic raise();  op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, g); endtask
    task automatic lower();  op(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, g); endtask
    task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
        op(a, 1, 0, 0, 0, 0, 0, 0, 0, 0, g);
        chk(tag, g, e);
    endtask
    task automatic irq_exp(input logic e, input string tag);
        #1 chk(tag, {7'h0, irq}, {7'h0, e});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        irq_exp(0, "R1");
        rd_exp(2, 8'h01, "R1");
        rd_exp(5, 8'h60, "R1");
        rd_exp(6, 8'h00, "R1");
        rd_exp(1, 8'h00, "R1");
        rd_exp(0, 8'h00, "R1");
        // R12 plain registers and ignored offsets
        wr(3, 8'h1B); wr(4, 8'h03); wr(7, 8'hA5);
        rd_exp(3, 8'h1B, "R12"); rd_exp(4, 8'h03, "R12"); rd_exp(7, 8'hA5, "R12");
        wr(2, 8'hFF); rd_exp(2, 8'h01, "R12");
        wr(5, 8'hFF); rd_exp(5, 8'h60, "R12");
        wr(6, 8'hFF); rd_exp(6, 8'h00, "R12");
        // R2 divisor latch
        wr(3, 8'h80); wr(0, 8'h34);
        irq_exp(0, "R2");
        chk("R2", {7'h0, tx_strobe}, 8'h00);
        wr(1, 8'h12);
        rd_exp(0, 8'h34, "R2"); rd_exp(1, 8'h12, "R2");
        wr(3, 8'h03);
        rd_exp(1, 8'h00, "R2");
        // R3 transmit hand-off
        wr(0, 8'h5A);
        #1 chk("R3", {7'h0, tx_strobe}, 8'h01);
        chk("R3", tx_byte, 8'h5A);
        rd_exp(5, 8'h00, "R3");
        rd_exp(5, 8'h60, "R3");
        // R6 injection and overrun, R11 gating with IER clear
        push(8'h41);
        irq_exp(0, "R11");
        rd_exp(5, 8'h61, "R6");
        push(8'h42);
        rd_exp(5, 8'h63, "R6");
        rd_exp(5, 8'h61, "R4");
        rd_exp(0, 8'h42, "R5");
        rd_exp(5, 8'h60, "R5");
        // R4 external OR-in
        op(5, 1, 0, 0, 0, 0, 0, 0, 0, 8'h80, g);
        chk("R4", g, 8'hE0);
        // R7 break
        brk();
        rd_exp(5, 8'h79, "R7");
        rd_exp(5, 8'h61, "R7");
        rd_exp(0, 8'h00, "R7");
        // R8 modem signals
        raise();
        rd_exp(6, 8'hBB, "R8"); rd_exp(6, 8'hB0, "R8");
        lower();
        rd_exp(6, 8'h0B, "R8"); rd_exp(6, 8'h00, "R8");
        // R10 priority, R11 readback
        wr(1, 8'hFF);
        rd_exp(1, 8'h0F, "R11");
        push(8'h01); push(8'h02);
        irq_exp(1, "R10");
        rd_exp(2, 8'h06, "R10");
        rd_exp(5, 8'h63, "R10");
        rd_exp(2, 8'h04, "R10");
        raise();
        rd_exp(2, 8'h04, "R10");
        rd_exp(0, 8'h02, "R10");
        rd_exp(2, 8'h00, "R10");
        rd_exp(6, 8'hBB, "R10");
        rd_exp(2, 8'h01, "R10");
        irq_exp(0, "R10");
        // R9 transmitter-empty interrupt
        wr(1, 8'h02);
        wr(0, 8'h11);
        idle();
        irq_exp(0, "R9");
        rd_exp(5, 8'h60, "R9");
        irq_exp(1, "R9");
        rd_exp(2, 8'h02, "R9");
        rd_exp(2, 8'h01, "R9");
        rd_exp(5, 8'h60, "R9");
        irq_exp(0, "R9");
        wr(0, 8'h22);
        rd_exp(5, 8'h00, "R9");
        irq_exp(0, "R9");
        rd_exp(5, 8'h60, "R9");
        irq_exp(1, "R9");
        wr(0, 8'h33);
        irq_exp(0, "R9");
        idle();
        // R5 loopback read drops THRE
        wr(1, 8'h00); wr(4, 8'h10);
        rd_exp(4, 8'h10, "R12");
        push(8'h55);
        rd_exp(0, 8'h55, "R5");
        rd_exp(5, 8'h00, "R5");
        rd_exp(5, 8'h60, "R5");
        wr(4, 8'h00);
        idle();
        report();
    end

endmodule